// File: doc/BRIEF.md
# Start-Gated Reseeded Pseudo-Random Word Generator

This block supplies cheap pseudo-random words, 256 bits wide by default, from a linear feedback shift register. Every time the processor starts a run, the register is reseeded from an external entropy source. A start pulse makes the block raise an entropy request and assert a stall output, so the core cannot fetch instructions.

The seed is taken in the cycle where the request and the acknowledge are both high, and it is loaded into the register. The stall then stays asserted for exactly one more cycle and drops. From that point on the register advances one step on every cycle where the step enable is high. The register state is always presented on the output as the value of a wide read-only special register.

If the entropy source delivers an all-zero seed, the block loads a fixed non-zero constant in its place, so the register never locks up.

Top module: `run_seeded_prng`

## Requirements
- R1: After reset, `hold_o` and `seed_req_o` are low and `rnd_o` equals the reset constant, which is the 32-bit word 0xA5C31E97 repeated across the width.
- R2: A start pulse sampled at a clock edge while no request is pending raises both `seed_req_o` and `hold_o` from the next cycle. Both stay high until a seed is taken.
- R3: A seed is taken at an edge where `seed_req_o` and `seed_ack_i` are both high. In the following cycle `seed_req_o` is low and `hold_o` is still high. One cycle later `hold_o` is low, unless a new start pulse has arrived.
- R4: `rnd_o` is the register state. At an edge where the block is seeded and running, `hold_o` is low, `step_i` is high and `run_start_i` is low, the state s becomes {s[254:0], s[255]^s[253]^s[250]^s[245]}.
- R5: A non-zero seed that is taken appears unchanged on `rnd_o` in the next cycle.
- R6: An all-zero seed is replaced by the fallback constant, which is the 32-bit word 0x3C96D2E1 repeated across the width.
- R7: `step_i` has no effect while `hold_o` is high, and none before the first seed after reset.
- R8: A start pulse while a request is pending issues no second request. `seed_req_o` stays high without a gap, and a single seed completes the reseed.
- R9: `seed_ack_i` while `seed_req_o` is low is ignored: `rnd_o` and `hold_o` do not change because of it.
- R10: A start pulse while running begins a new reseed. `hold_o` rises again, and the output then continues from the new seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_start_i | input | 1 | One-cycle pulse marking the start of a run |
| seed_ack_i | input | 1 | Entropy source acknowledge; seed data is valid when this is high |
| seed_data_i | input | Width | Seed word from the entropy source |
| step_i | input | 1 | Advance the register by one step |
| hold_o | output | 1 | Stall to the core; fetch is blocked while high |
| seed_req_o | output | 1 | Entropy request |
| rnd_o | output | Width | Current pseudo-random word |

## Verification
The hardest cases to reach are the overlaps: a start pulse landing while a request is still pending, and a start pulse landing in the single settle cycle after a seed is taken. Both need the start pulse to arrive within a narrow window relative to the acknowledge. The directed part of the bench places a repeated start between the request and a deliberately delayed acknowledge. The random part fires starts, acknowledges and zero seeds with independent probabilities over thousands of cycles, so starts fall on every phase. A cycle-by-cycle reference model in the bench predicts the stall, the request and the output word throughout.

// File: rtl/run_prng_pkg.sv
package run_prng_pkg;

  // Phases of a run as seen by the generator
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,  // after reset, never seeded
    PH_REQ    = 2'd1,  // waiting for entropy, stall high
    PH_SETTLE = 2'd2,  // seed loaded, one extra stall cycle
    PH_RUN    = 2'd3   // seeded, stall low, stepping allowed
  } prng_phase_e;

endpackage

// File: rtl/prng_seq_ctrl.sv
module prng_seq_ctrl
  import run_prng_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic take_i,
  output logic req_o,
  output logic hold_o,
  output logic running_o
);

  prng_phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_REQ:    if (take_i) phase_d = PH_SETTLE;
      PH_SETTLE: phase_d = start_i ? PH_REQ : PH_RUN;
      default:   if (start_i) phase_d = PH_REQ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  assign req_o     = (phase_q == PH_REQ);
  assign hold_o    = (phase_q == PH_REQ) || (phase_q == PH_SETTLE);
  assign running_o = (phase_q == PH_RUN);

endmodule

// File: rtl/prng_lfsr_core.sv
module prng_lfsr_core #(
  parameter int Width = 256,
  parameter int TapA  = 256,
  parameter int TapB  = 254,
  parameter int TapC  = 251,
  parameter int TapD  = 246,
  parameter logic [Width-1:0] ResetState   = '1,
  parameter logic [Width-1:0] ZeroFallback = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [Width-1:0] seed_i,
  input  logic             adv_i,
  output logic [Width-1:0] state_o
);

  // One Fibonacci step, taps given as 1-based positions
  function automatic logic [Width-1:0] lfsr_next(input logic [Width-1:0] s);
    logic fb;
    fb = s[TapA-1] ^ s[TapB-1] ^ s[TapC-1] ^ s[TapD-1];
    return {s[Width-2:0], fb};
  endfunction

  // All-zero seed would lock the register, substitute the fallback
  function automatic logic [Width-1:0] seed_fix(input logic [Width-1:0] s);
    return (s == '0) ? ZeroFallback : s;
  endfunction

  logic [Width-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= ResetState;
    else if (load_i) state_q <= seed_fix(seed_i);
    else if (adv_i)  state_q <= lfsr_next(state_q);
  end

  assign state_o = state_q;

endmodule

// File: rtl/run_seeded_prng.sv
module run_seeded_prng #(
  parameter int Width = 256,
  parameter int TapA  = 256,
  parameter int TapB  = 254,
  parameter int TapC  = 251,
  parameter int TapD  = 246,
  localparam int Words = Width / 32,
  parameter logic [Width-1:0] ResetState   = {Words{32'hA5C31E97}},
  parameter logic [Width-1:0] ZeroFallback = {Words{32'h3C96D2E1}}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_start_i,
  input  logic             seed_ack_i,
  input  logic [Width-1:0] seed_data_i,
  input  logic             step_i,
  output logic             hold_o,
  output logic             seed_req_o,
  output logic [Width-1:0] rnd_o
);

  // Named internal events, observed by the bound checker
  logic running;
  logic seed_take;
  logic lfsr_adv;

  prng_seq_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (run_start_i),
    .take_i   (seed_take),
    .req_o    (seed_req_o),
    .hold_o   (hold_o),
    .running_o(running)
  );

  assign seed_take = seed_req_o & seed_ack_i;
  assign lfsr_adv  = running & step_i & ~run_start_i;

  prng_lfsr_core #(
    .Width       (Width),
    .TapA        (TapA),
    .TapB        (TapB),
    .TapC        (TapC),
    .TapD        (TapD),
    .ResetState  (ResetState),
    .ZeroFallback(ZeroFallback)
  ) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (seed_take),
    .seed_i (seed_data_i),
    .adv_i  (lfsr_adv),
    .state_o(rnd_o)
  );

endmodule

// File: rtl/run_prng_chk.sv
module run_prng_chk #(
  parameter int Width = 256
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_start_i,
  input logic             seed_ack_i,
  input logic [Width-1:0] seed_data_i,
  input logic             step_i,
  input logic             hold_o,
  input logic             seed_req_o,
  input logic [Width-1:0] rnd_o,
  input logic             seed_take,
  input logic             lfsr_adv
);

  AST_REQ_MEANS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_req_o |-> hold_o);  // R2

  AST_SETTLE_AFTER_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_take |=> (hold_o && !seed_req_o));  // R3

  AST_RELEASE_AFTER_SETTLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && !seed_req_o && !run_start_i) |=> !hold_o);  // R3

  AST_SEED_LOADED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seed_req_o && seed_ack_i && (seed_data_i != '0)) |=> (rnd_o == $past(seed_data_i)));  // R5

  AST_ZERO_SEED_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seed_req_o && seed_ack_i && (seed_data_i == '0)) |=> (rnd_o != '0));  // R6

  AST_STALL_FREEZES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && !seed_take) |=> $stable(rnd_o));  // R7

  AST_NO_ADV_IN_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> !lfsr_adv);  // R7

  AST_REQ_NO_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seed_req_o && !seed_ack_i) |=> seed_req_o);  // R8

  AST_STRAY_ACK_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seed_req_o && seed_ack_i && !step_i && !run_start_i) |=> $stable(rnd_o));  // R9

  AST_RESTART_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_o && run_start_i) |=> (hold_o && seed_req_o));  // R10

endmodule

bind run_seeded_prng run_prng_chk #(.Width(Width)) u_prng_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .run_start_i(run_start_i),
  .seed_ack_i (seed_ack_i),
  .seed_data_i(seed_data_i),
  .step_i     (step_i),
  .hold_o     (hold_o),
  .seed_req_o (seed_req_o),
  .rnd_o      (rnd_o),
  .seed_take  (seed_take),
  .lfsr_adv   (lfsr_adv)
);

// File: tb/run_seeded_prng_bench.sv
module run_seeded_prng_bench;

  localparam int W = 256;
  localparam logic [W-1:0] RST_VAL = {8{32'hA5C31E97}};
  localparam logic [W-1:0] FB_VAL  = {8{32'h3C96D2E1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic ack = 1'b0;
  logic [W-1:0] data = '0;
  logic step = 1'b0;
  logic hold, req;
  logic [W-1:0] rnd;

  always #2.5 clk = ~clk;

  run_seeded_prng u_run_seeded_prng (
    .clk_i(clk), .rst_ni(rst_n), .run_start_i(start), .seed_ack_i(ack),
    .seed_data_i(data), .step_i(step), .hold_o(hold), .seed_req_o(req), .rnd_o(rnd)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference model: 0 idle, 1 requesting, 2 settle, 3 running
  int m_ph = 0;
  logic [W-1:0] m_val = RST_VAL;

  function automatic logic [W-1:0] exp_advance(input logic [W-1:0] s);
    int taps [4] = '{255, 253, 250, 245};
    logic x = 1'b0;
    foreach (taps[i]) x ^= s[taps[i]];
    return (s << 1) | W'(x);
  endfunction

  task automatic chk(input bit ok, input string req_tag, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  // Apply current inputs to the model, pass one edge, compare all outputs
  task automatic cyc();
    if (m_ph == 1 && ack) begin
      m_val = (data == '0) ? FB_VAL : data;
      m_ph  = 2;
    end else if (start && m_ph != 1) begin
      m_ph = 1;
    end else if (m_ph == 2) begin
      m_ph = 3;
    end else if (m_ph == 3 && step) begin
      m_val = exp_advance(m_val);
    end
    @(negedge clk);
    chk(req == (m_ph == 1), "R2", W'(req), W'(m_ph == 1));
    chk(hold == (m_ph == 1 || m_ph == 2), "R3", W'(hold), W'(m_ph == 1 || m_ph == 2));
    chk(rnd == m_val, "R4", rnd, m_val);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [W-1:0] rand_word();
    logic [W-1:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] seed_a;
    logic [W-1:0] snap;
    int req_rises;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(!hold && !req, "R1", {hold, req}, 2'b00);
    chk(rnd == RST_VAL, "R1", rnd, RST_VAL);

    // R7: steps before the first seed do nothing
    step = 1'b1;
    repeat (4) cyc();
    chk(rnd == RST_VAL, "R7", rnd, RST_VAL);
    step = 1'b0;

    // R9: stray acknowledge with no request
    ack = 1'b1; data = rand_word();
    repeat (2) cyc();
    chk(rnd == RST_VAL && !hold, "R9", rnd, RST_VAL);
    ack = 1'b0;

    // R2 / R8: start, then a repeated start while the request is pending
    start = 1'b1; cyc(); start = 1'b0;
    chk(req && hold, "R2", {req, hold}, 2'b11);
    req_rises = 1;
    cyc();
    start = 1'b1; step = 1'b1; cyc(); start = 1'b0;
    chk(req, "R8", W'(req), 1);
    cyc(); step = 1'b0;
    chk(req && rnd == RST_VAL, "R8", rnd, RST_VAL);

    // R5 / R3: seed accepted, one settle cycle, then release
    seed_a = rand_word() | 1;
    data = seed_a; ack = 1'b1; cyc(); ack = 1'b0; data = '0;
    chk(rnd == seed_a, "R5", rnd, seed_a);
    chk(hold && !req, "R3", {hold, req}, 2'b10);
    cyc();
    chk(!hold, "R3", W'(hold), 0);
    if (req) req_rises++;
    chk(req_rises == 1, "R8", W'(req_rises), 1);

    // R4: three steps
    snap = exp_advance(exp_advance(exp_advance(seed_a)));
    step = 1'b1; repeat (3) cyc(); step = 1'b0;
    chk(rnd == snap, "R4", rnd, snap);

    // R10 / R6: restart while running, zero seed
    start = 1'b1; cyc(); start = 1'b0;
    chk(hold && req, "R10", {hold, req}, 2'b11);
    ack = 1'b1; data = '0; cyc(); ack = 1'b0;
    chk(rnd == FB_VAL, "R6", rnd, FB_VAL);
    cyc();
    step = 1'b1; cyc(); step = 1'b0;
    chk(rnd == exp_advance(FB_VAL), "R10", rnd, exp_advance(FB_VAL));

    // Constrained random phase, checked every cycle against the model
    for (int n = 0; n < 4000; n++) begin
      start = ($urandom_range(0, 29) == 0);
      ack   = ($urandom_range(0, 3) == 0);
      step  = ($urandom_range(0, 1) == 1);
      data  = ($urandom_range(0, 9) == 0) ? '0 : rand_word();
      cyc();
    end
    start = 1'b0; ack = 1'b0; step = 1'b0;
    finish_run();
  end

endmodule